// File: doc/BRIEF.md
# Two-Section Decade Counter with Selectable Cascade

This block is a small event counter made of two stages: a one-bit toggle stage (divide by two, output `qa`) and a three-bit stage that cycles through five states (outputs `qd`, `qc`, `qb`, with `qd` as the most significant bit). Each stage has its own count input. A stage advances only when its count input goes from high to low. Both count inputs are sampled by one system clock through synchronizers, so the inputs may be asynchronous to that clock.

A mode input chooses how the stages are joined inside the block. In split mode the stages are independent. In BCD mode the falling edge of `qa` advances the five-state stage, so the four outputs count a decade in binary-coded decimal. In bi-quinary mode the five-state stage is driven from outside and the falling edge of `qd` toggles `qa`, which gives a divide-by-ten output with a 50% duty cycle on `qa`. A registered flag pulses when a decade mode rolls over to zero. An active-high reset clears the block at once, and the block leaves reset in step with the clock.

Top module: `dual_section_counter`

## Requirements
- R1: A stage advances only on a high-to-low transition of the input that drives it. A low-to-high transition leaves every output unchanged.
- R2: While `rst` is high, `qa`, `qb`, `qc`, `qd` and `tc` are 0 without waiting for a clock edge. No input activity changes them while `rst` stays high.
- R3: The five-state stage, read as {qd,qc,qb}, steps 0,1,2,3,4 and then returns to 0. It never holds a value above 4.
- R4: In split mode (`mode`=2'b00), or with the spare code 2'b11, each falling edge of `cnt_a` inverts `qa`.
- R5: In BCD mode (`mode`=2'b01), each falling edge of `cnt_a` moves {qd,qc,qb,qa} one step through 0..9, and 9 is followed by 0. `cnt_b` has no effect in this mode.
- R6: In bi-quinary mode (`mode`=2'b10), each falling edge of `cnt_b` moves {qa,qd,qc,qb} through 0,1,2,3,4,8,9,10,11,12 and then back to 0. `cnt_a` has no effect in this mode.
- R7: In bi-quinary mode, starting from reset, `qa` is high after exactly five of every ten consecutive `cnt_b` falling edges, as five highs in a row followed by five lows in a row.
- R8: In split mode the two stages count only from their own inputs, so `cnt_b` edges advance {qd,qc,qb} and `cnt_a` edges toggle `qa`.
- R9: With the default two synchronizer stages, an output driven from an input edge changes on the third rising clock edge after the input change. A cascaded stage changes one clock edge later than the stage that drives it.
- R10: After reset is released, a count input that is already low, or that falls while the synchronizers refill, causes no count. A high level has to be seen after release before a falling edge is counted.
- R11: `tc` is high for exactly one clock cycle, the first cycle in which a decade mode shows 0 after its last state. `tc` stays low in split mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Active-high reset; asserts asynchronously, releases synchronously |
| mode | input | 2 | Cascade select: 00 split, 01 BCD, 10 bi-quinary, 11 split |
| cnt_a | input | 1 | Count input of the divide-by-two stage |
| cnt_b | input | 1 | Count input of the divide-by-five stage |
| qa | output | 1 | Divide-by-two stage output |
| qb | output | 1 | Five-state stage, bit 0 |
| qc | output | 1 | Five-state stage, bit 1 |
| qd | output | 1 | Five-state stage, bit 2 (most significant) |
| tc | output | 1 | One-cycle decade rollover flag |

## Verification
The bench builds the block with its default two input synchronizer stages and two reset-release stages. With these values the cycle of every output change is fixed, so the bench can check the latency of the direct path and of the cascaded path to the exact clock edge. It can also check that an input which falls in the refill window after reset is ignored. Random falling-edge sequences run in all four mode codes, and each one is compared against a bench model. This covers both decade rollovers, the `tc` pulse, and the input that each decade mode leaves unused.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'b00,
        MODE_BCD   = 2'b01,
        MODE_BIQ   = 2'b10,
        MODE_SPARE = 2'b11
    } cascade_mode_e;

    localparam int          QUIN_W    = 3;
    localparam int          QUIN_MOD  = 5;
    localparam logic [QUIN_W-1:0] QUIN_LAST = QUIN_W'(QUIN_MOD - 1);

    typedef logic [QUIN_W-1:0] quin_t;

    // Advance requests for the two stages in one cycle
    typedef struct packed {
        logic adv2;
        logic adv5;
    } adv_t;

    function automatic quin_t quin_next(input quin_t s);
        return (s >= QUIN_LAST) ? '0 : quin_t'(s + 1'b1);
    endfunction

    function automatic logic is_decade(input cascade_mode_e m);
        return (m == MODE_BCD) || (m == MODE_BIQ);
    endfunction

endpackage

// File: rtl/dsc_reset_sync.sv
module dsc_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] hold;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or posedge rst_in) begin
            if (rst_in) begin
                hold[i] <= 1'b1;
            end else begin
                if (i == 0) hold[i] <= 1'b0;
                else        hold[i] <= hold[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign rst_out = hold[STAGES-1];
endmodule

// File: rtl/dsc_edge_sync.sv
module dsc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                chain[i] <= 1'b0;
            end else begin
                if (i == 0) chain[i] <= din;
                else        chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    // Seen high last cycle, low now: one-cycle pulse
    assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/dsc_stages.sv
module dsc_div2_stage (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)      q <= 1'b0;
        else if (adv) q <= ~q;
    end
endmodule

module dsc_div5_stage
    import dsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output quin_t q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)      q <= '0;
        else if (adv) q <= quin_next(q);
    end
endmodule

// File: rtl/dual_section_counter.sv
module dual_section_counter
    import dsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       cnt_a,
    input  logic       cnt_b,
    output logic       qa,
    output logic       qb,
    output logic       qc,
    output logic       qd,
    output logic       tc
);
    cascade_mode_e mode_e;
    logic          rst_i;
    logic          fall_a, fall_b;
    logic          qa_prev, qd_prev;
    logic          qa_drop, qd_drop;
    adv_t          adv;
    quin_t         quin;

    assign mode_e = cascade_mode_e'(mode);

    dsc_reset_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk(clk), .rst_in(rst), .rst_out(rst_i)
    );

    dsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst(rst_i), .din(cnt_a), .fall(fall_a)
    );

    dsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst(rst_i), .din(cnt_b), .fall(fall_b)
    );

    // Internal cascade taps: a stage output falling, seen one cycle late
    always_ff @(posedge clk or posedge rst_i) begin
        if (rst_i) begin
            qa_prev <= 1'b0;
            qd_prev <= 1'b0;
        end else begin
            qa_prev <= qa;
            qd_prev <= quin[2];
        end
    end

    assign qa_drop = qa_prev & ~qa;
    assign qd_drop = qd_prev & ~quin[2];

    always_comb begin
        unique case (mode_e)
            MODE_BCD: begin
                adv.adv2 = fall_a;
                adv.adv5 = qa_drop;
            end
            MODE_BIQ: begin
                adv.adv2 = qd_drop;
                adv.adv5 = fall_b;
            end
            default: begin
                adv.adv2 = fall_a;
                adv.adv5 = fall_b;
            end
        endcase
    end

    dsc_div2_stage u_div2 (
        .clk(clk), .rst(rst_i), .adv(adv.adv2), .q(qa)
    );

    dsc_div5_stage u_div5 (
        .clk(clk), .rst(rst_i), .adv(adv.adv5), .q(quin)
    );

    // Rollover flag, set by the update that brings the decade back to 0
    always_ff @(posedge clk or posedge rst_i) begin
        if (rst_i) begin
            tc <= 1'b0;
        end else begin
            tc <= ((mode_e == MODE_BCD) && adv.adv5 && (quin == QUIN_LAST)) ||
                  ((mode_e == MODE_BIQ) && adv.adv2 && qa);
        end
    end

    assign qb = quin[0];
    assign qc = quin[1];
    assign qd = quin[2];
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       qa,
    input logic       qb,
    input logic       qc,
    input logic       qd,
    input logic       tc
);
    logic [2:0] quin;
    assign quin = {qd, qc, qb};

    // R2: reset holds every output low
    assert_reset_clear_R2: assert property (@(posedge clk)
        rst |-> (!qa && !qb && !qc && !qd && !tc));

    // R3: five-state stage stays in range
    assert_quin_range_R3: assert property (@(posedge clk) disable iff (rst)
        quin <= 3'd4);

    // R3: five-state stage only moves by one step
    assert_quin_step_R3: assert property (@(posedge clk) disable iff (rst)
        (quin != $past(quin)) |->
            (quin == (($past(quin) == 3'd4) ? 3'd0 : $past(quin) + 3'd1)));

    // R11: flag lasts a single cycle
    assert_tc_single_R11: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);

    // R11: flag only marks a zero word reached in a decade mode
    assert_tc_zero_R11: assert property (@(posedge clk) disable iff (rst)
        tc |-> (!qa && quin == 3'd0 &&
                ($past(mode) == 2'b01 || $past(mode) == 2'b10)));
endmodule

bind dual_section_counter dsc_checker u_chk (
    .clk(clk), .rst(rst), .mode(mode),
    .qa(qa), .qb(qb), .qc(qc), .qd(qd), .tc(tc)
);

// File: tb/dual_section_counter_tb.sv
module dual_section_counter_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       cnt_a = 1'b0;
    logic       cnt_b = 1'b0;
    logic       qa, qb, qc, qd, tc;

    int checks = 0;
    int errors = 0;
    int tc_count = 0;
    int m2 = 0;
    int m5 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_section_counter u_dut (
        .clk(clk), .rst(rst), .mode(mode), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .qa(qa), .qb(qb), .qc(qc), .qd(qd), .tc(tc)
    );

    always @(negedge clk) if (tc) tc_count++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int word();
        return {28'd0, qd, qc, qb, qa};
    endfunction

    function automatic int model_word();
        return m5 * 2 + m2;
    endfunction

    // Bench model of one input falling edge; returns 1 on a decade rollover
    task automatic model_fall(input bit is_a, output bit wrap);
        wrap = 1'b0;
        if (mode == 2'b01) begin
            if (is_a) begin
                if (m2 == 1) begin
                    m2 = 0;
                    if (m5 == 4) wrap = 1'b1;
                    m5 = (m5 + 1) % 5;
                end else m2 = 1;
            end
        end else if (mode == 2'b10) begin
            if (!is_a) begin
                if (m5 == 4) begin
                    m5 = 0;
                    if (m2 == 1) wrap = 1'b1;
                    m2 = 1 - m2;
                end else m5 = m5 + 1;
            end
        end else begin
            if (is_a) m2 = 1 - m2;
            else      m5 = (m5 + 1) % 5;
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1;
        cnt_a = 1'b0;
        cnt_b = 1'b0;
        mode = m;
        m2 = 0;
        m5 = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // One full pulse on a chosen input, checked after rise and after fall
    task automatic pulse(input bit is_a, input string tag);
        bit wrap;
        int tc_before;
        if (is_a) cnt_a = 1'b1; else cnt_b = 1'b1;
        repeat (5) @(negedge clk);
        chk({tag, "/R1 rise no effect"}, word(), model_word());
        tc_before = tc_count;
        if (is_a) cnt_a = 1'b0; else cnt_b = 1'b0;
        model_fall(is_a, wrap);
        repeat (7) @(negedge clk);
        chk({tag, " word"}, word(), model_word());
        chk({tag, "/R11 tc"}, tc_count - tc_before, wrap ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));

        // R2: state during reset
        repeat (2) @(negedge clk);
        chk("R2 reset word", word(), 0);
        chk("R2 reset tc", {31'd0, tc}, 0);

        // R9: latency of the direct path (split mode)
        do_reset(2'b00);
        cnt_a = 1'b1;
        repeat (5) @(negedge clk);
        cnt_a = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 before third edge", {31'd0, qa}, 0);
        @(negedge clk);
        chk("R9 at third edge / R4", {31'd0, qa}, 1);

        // R9: cascaded stage lags by one edge (BCD, word 1 -> 2)
        do_reset(2'b01);
        pulse(1'b1, "R5");
        cnt_a = 1'b1;
        repeat (5) @(negedge clk);
        cnt_a = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 cascade source", word(), 0);
        @(negedge clk);
        chk("R9 cascade target", word(), 2);
        m2 = 0; m5 = 1;

        // R10: input low through release, and falling during refill
        @(negedge clk);
        rst = 1'b1;
        cnt_a = 1'b1;
        mode = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cnt_a = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 fall during refill", word(), 0);
        cnt_b = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 low through release", word(), 0);
        m2 = 0; m5 = 0;
        pulse(1'b1, "R10 first real edge");

        // R2: asynchronous clear mid-cycle and blocked counting
        do_reset(2'b00);
        pulse(1'b0, "R8");
        pulse(1'b0, "R8");
        pulse(1'b1, "R4");
        @(negedge clk);
        #(CLK_PERIOD/4);
        rst = 1'b1;
        #1;
        chk("R2 immediate clear", word(), 0);
        for (int i = 0; i < 3; i++) begin
            cnt_a = 1'b1; cnt_b = 1'b1;
            repeat (4) @(negedge clk);
            cnt_a = 1'b0; cnt_b = 1'b0;
            repeat (4) @(negedge clk);
        end
        chk("R2 counting blocked", word(), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        m2 = 0; m5 = 0;

        // R7: duty cycle of qa in bi-quinary mode
        do_reset(2'b10);
        begin
            int highs = 0;
            int first_half = 0;
            for (int i = 0; i < 10; i++) begin
                pulse(1'b0, "R6");
                if (qa) begin
                    highs++;
                    if (i < 5) first_half++;
                end
            end
            chk("R7 qa high count", highs, 5);
            chk("R7 qa high run placement", first_half, 1);
            chk("R7 qa after ten edges", {31'd0, qa}, 0);
        end

        // R3/R5/R6/R8: random edge sequences in every mode code
        for (int m = 0; m < 4; m++) begin
            string tag;
            tag = (m == 1) ? "R5" : (m == 2) ? "R6" : (m == 0) ? "R8" : "R4";
            do_reset(m[1:0]);
            for (int n = 0; n < 45; n++) begin
                pulse(($urandom % 2) == 1, tag);
                chk("R3 quin range", (m5 <= 4) ? 1 : 0, 1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule